// File: doc/BRIEF.md
# Parallel ATA PIO Strobe Timing Generator

This block times the three phases of a programmed-I/O transfer on a parallel ATA bus: address setup, strobe active and strobe recovery. Each phase lasts a number of host clocks taken from per-drive timing registers. After the recovery phase the block gives a one-cycle completion pulse. Software loads the timing values through a small byte-wide write port. A transfer request picks the drive (master or slave), the direction (read or write) and the width (16-bit data or 8-bit command).

Each timing field is four bits wide and holds the clock count minus one. A field of 0 gives one clock and a field of 0xF gives sixteen. The two drives keep their setup counts in separate nibbles of one packed setup register. For each drive there are three timing bytes: 16-bit read, 16-bit write and 8-bit command. The upper nibble of a timing byte holds the active count and the lower nibble holds the recovery count.

The state machine has five states: IDLE, SETUP, ACTIVE, RECOVER and DONE. The transitions are:
- IDLE→SETUP when a request arrives.
- SETUP→ACTIVE when the setup count runs out.
- ACTIVE→RECOVER when the active count runs out.
- RECOVER→DONE when the recovery count runs out.
- DONE→IDLE always, after one cycle.

The setup, active and recovery counts are captured when the request is accepted.

Top module: `ide_pio_strobe_gen`

## Requirements
- R1: Reset returns the block to IDLE with both strobes high and busy, address-valid and done low, and clears every timing field to zero, so a transfer issued straight after reset has one-clock setup, active and recovery phases.
- R2: Each phase lasts its field value plus one clocks, from 1 clock for field 0 to 16 clocks for field 0xF.
- R3: In a timing byte, bits 7:4 set the active (strobe low) length and bits 3:0 set the recovery length.
- R4: A write to offset 0x0 loads the master setup count from data bits 3:0. A write to offset 0x1 loads the slave setup count from data bits 3:0. Each of these writes leaves the other drive's setup count unchanged.
- R5: The timing bytes are at these offsets:

  | Drive | 16-bit read | 16-bit write | 8-bit command |
  |-------|-------------|--------------|---------------|
  | master | 0x4 | 0x5 | 0x6 |
  | slave | 0x8 | 0x9 | 0xA |

- R6: The selected drive's timing byte is chosen as follows: a 16-bit read (req_narrow=0, req_write=0) uses its read byte, and a 16-bit write uses its write byte. An 8-bit access (req_narrow=1) uses its command byte in either direction. req_drive=0 selects the master and req_drive=1 selects the slave.
- R7: A transfer runs in a fixed order:
  - Setup: address_valid is high and both strobes are high.
  - Active: only the selected strobe is low (dior_n for a read, diow_n for a write) and address_valid stays high.
  - Recovery: both strobes are high and address_valid is high.
  - Done: one cycle with done high and address_valid low.
- R8: busy is high from the cycle after the request is accepted through the done cycle, and low in IDLE.
- R9: A request presented while busy is high is ignored, and the block returns to IDLE after the done cycle.
- R10: Writes to any offset other than 0x0, 0x1, 0x4–0x6 and 0x8–0xA change no timing value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Host bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Timing register write strobe |
| cfg_addr | input | ADDR_W (4) | Register offset |
| cfg_wdata | input | 2*NIB_W (8) | Register write data |
| req_valid | input | 1 | Transfer request, accepted only in IDLE |
| req_drive | input | 1 | 0 = master, 1 = slave |
| req_write | input | 1 | 0 = read, 1 = write |
| req_narrow | input | 1 | 0 = 16-bit data, 1 = 8-bit command |
| busy | output | 1 | Transfer in progress |
| addr_valid | output | 1 | Address lines valid to the drive |
| dior_n | output | 1 | Read strobe, active low |
| diow_n | output | 1 | Write strobe, active low |
| done | output | 1 | One-cycle completion pulse |

## Verification
The clock edge that samples a request moves the block into SETUP, so the first setup cycle is visible one edge after that edge. The done pulse follows after setup+1, active+1 and recovery+1 further cycles. One more edge returns busy low. The bench samples all outputs on the falling edge. Starting from the sample right after the accepting edge, it counts how many consecutive samples fall into each phase and compares those lengths with counts computed from its own model of the programmed fields. It also checks busy on the sample that follows the done pulse. Register writes take effect on the edge that samples them, so every transfer is started at least one edge after its last configuration write.

// File: rtl/ide_pio_pkg.sv
package ide_pio_pkg;
    localparam int NIB_W          = 4;
    localparam int N_DRIVES       = 2;
    localparam int N_KINDS        = 3;
    localparam int OFF_SETUP_BASE = 0;
    localparam int OFF_TIM_STRIDE = 4;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_ACTIVE,
        ST_RECOVER,
        ST_DONE
    } pio_state_e;

    typedef enum logic [1:0] {
        KIND_RD     = 2'd0,
        KIND_WR     = 2'd1,
        KIND_NARROW = 2'd2
    } pio_kind_e;
endpackage

// File: rtl/pio_timing_regs.sv
module pio_timing_regs
    import ide_pio_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int NIB_W  = 4
) (
    input  logic                                              clk,
    input  logic                                              rst_n,
    input  logic                                              we,
    input  logic [ADDR_W-1:0]                                 addr,
    input  logic [2*NIB_W-1:0]                                wdata,
    output logic [N_DRIVES-1:0][NIB_W-1:0]                    setup_q,
    output logic [N_DRIVES-1:0][N_KINDS-1:0][2*NIB_W-1:0]     tim_q
);
    localparam int BYTE_W = 2 * NIB_W;

    for (genvar d = 0; d < N_DRIVES; d++) begin : g_drive
        localparam logic [ADDR_W-1:0] SET_OFF = ADDR_W'(OFF_SETUP_BASE + d);
        logic [NIB_W-1:0] set_r;

        // the packed setup word keeps each drive's nibble apart
        always_ff @(posedge clk) begin
            if (!rst_n)
                set_r <= '0;
            else if (we && addr == SET_OFF)
                set_r <= wdata[NIB_W-1:0];
        end
        assign setup_q[d] = set_r;

        for (genvar k = 0; k < N_KINDS; k++) begin : g_kind
            localparam logic [ADDR_W-1:0] TIM_OFF = ADDR_W'(OFF_TIM_STRIDE * (d + 1) + k);
            logic [BYTE_W-1:0] tim_r;

            always_ff @(posedge clk) begin
                if (!rst_n)
                    tim_r <= '0;
                else if (we && addr == TIM_OFF)
                    tim_r <= wdata;
            end
            assign tim_q[d][k] = tim_r;
        end
    end
endmodule

// File: rtl/pio_timing_sel.sv
module pio_timing_sel
    import ide_pio_pkg::*;
#(
    parameter int NIB_W = 4
) (
    input  logic [N_DRIVES-1:0][NIB_W-1:0]                setup_q,
    input  logic [N_DRIVES-1:0][N_KINDS-1:0][2*NIB_W-1:0] tim_q,
    input  logic                                          drive,
    input  logic                                          write,
    input  logic                                          narrow,
    output logic [NIB_W-1:0]                              setup_cnt,
    output logic [NIB_W-1:0]                              act_cnt,
    output logic [NIB_W-1:0]                              rec_cnt
);
    pio_kind_e          kind;
    logic [2*NIB_W-1:0] tbyte;

    always_comb begin
        if (narrow)
            kind = KIND_NARROW;
        else if (write)
            kind = KIND_WR;
        else
            kind = KIND_RD;
        tbyte     = tim_q[drive][kind];
        setup_cnt = setup_q[drive];
        act_cnt   = tbyte[2*NIB_W-1:NIB_W];
        rec_cnt   = tbyte[NIB_W-1:0];
    end
endmodule

// File: rtl/pio_phase_fsm.sv
module pio_phase_fsm
    import ide_pio_pkg::*;
#(
    parameter int NIB_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic             req_write,
    input  logic [NIB_W-1:0] setup_cnt,
    input  logic [NIB_W-1:0] act_cnt,
    input  logic [NIB_W-1:0] rec_cnt,
    output logic             busy,
    output logic             addr_valid,
    output logic             dior_n,
    output logic             diow_n,
    output logic             done
);
    pio_state_e       state;
    logic [NIB_W-1:0] cnt;
    logic [NIB_W-1:0] lat_act;
    logic [NIB_W-1:0] lat_rec;
    logic             lat_wr;
    logic             cnt_zero;

    assign cnt_zero = (cnt == '0);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            cnt     <= '0;
            lat_act <= '0;
            lat_rec <= '0;
            lat_wr  <= 1'b0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (req_valid) begin
                        state   <= ST_SETUP;
                        cnt     <= setup_cnt;
                        lat_act <= act_cnt;
                        lat_rec <= rec_cnt;
                        lat_wr  <= req_write;
                    end
                end
                ST_SETUP: begin
                    if (cnt_zero) begin
                        state <= ST_ACTIVE;
                        cnt   <= lat_act;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                ST_ACTIVE: begin
                    if (cnt_zero) begin
                        state <= ST_RECOVER;
                        cnt   <= lat_rec;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                ST_RECOVER: begin
                    if (cnt_zero)
                        state <= ST_DONE;
                    else
                        cnt <= cnt - 1'b1;
                end
                ST_DONE:  state <= ST_IDLE;
                default:  state <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        busy       = 1'b1;
        addr_valid = 1'b0;
        dior_n     = 1'b1;
        diow_n     = 1'b1;
        done       = 1'b0;
        unique case (state)
            ST_IDLE:    busy = 1'b0;
            ST_SETUP:   addr_valid = 1'b1;
            ST_ACTIVE: begin
                addr_valid = 1'b1;
                dior_n     = lat_wr;
                diow_n     = !lat_wr;
            end
            ST_RECOVER: addr_valid = 1'b1;
            ST_DONE:    done = 1'b1;
            default:    busy = 1'b0;
        endcase
    end
endmodule

// File: rtl/ide_pio_strobe_gen.sv
module ide_pio_strobe_gen
    import ide_pio_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int NIB_W  = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cfg_we,
    input  logic [ADDR_W-1:0]   cfg_addr,
    input  logic [2*NIB_W-1:0]  cfg_wdata,
    input  logic                req_valid,
    input  logic                req_drive,
    input  logic                req_write,
    input  logic                req_narrow,
    output logic                busy,
    output logic                addr_valid,
    output logic                dior_n,
    output logic                diow_n,
    output logic                done
);
    logic [N_DRIVES-1:0][NIB_W-1:0]                setup_q;
    logic [N_DRIVES-1:0][N_KINDS-1:0][2*NIB_W-1:0] tim_q;
    logic [NIB_W-1:0] setup_cnt;
    logic [NIB_W-1:0] act_cnt;
    logic [NIB_W-1:0] rec_cnt;

    pio_timing_regs #(.ADDR_W(ADDR_W), .NIB_W(NIB_W)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (cfg_we),
        .addr    (cfg_addr),
        .wdata   (cfg_wdata),
        .setup_q (setup_q),
        .tim_q   (tim_q)
    );

    pio_timing_sel #(.NIB_W(NIB_W)) u_sel (
        .setup_q   (setup_q),
        .tim_q     (tim_q),
        .drive     (req_drive),
        .write     (req_write),
        .narrow    (req_narrow),
        .setup_cnt (setup_cnt),
        .act_cnt   (act_cnt),
        .rec_cnt   (rec_cnt)
    );

    pio_phase_fsm #(.NIB_W(NIB_W)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_write  (req_write),
        .setup_cnt  (setup_cnt),
        .act_cnt    (act_cnt),
        .rec_cnt    (rec_cnt),
        .busy       (busy),
        .addr_valid (addr_valid),
        .dior_n     (dior_n),
        .diow_n     (diow_n),
        .done       (done)
    );
endmodule

// File: rtl/pio_strobe_checker.sv
module pio_strobe_checker (
    input logic clk,
    input logic rst_n,
    input logic busy,
    input logic addr_valid,
    input logic dior_n,
    input logic diow_n,
    input logic done
);
    // R7: never both strobes at once
    p_one_strobe_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(!dior_n && !diow_n));

    // R7: a low strobe always has a valid address
    p_strobe_has_addr_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!dior_n || !diow_n) |-> addr_valid);

    // R7: the strobe falls only after an address setup cycle
    p_setup_first_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(dior_n) || $fell(diow_n)) |-> $past(addr_valid));

    // R7: done lasts a single cycle
    p_done_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R8: busy drops right after done
    p_done_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy);

    // R9: a running transfer is not cut short
    p_busy_held_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> busy);

    // R1: when idle, all bus outputs are quiet
    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (dior_n && diow_n && !addr_valid && !done));
endmodule

bind ide_pio_strobe_gen pio_strobe_checker u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .busy       (busy),
    .addr_valid (addr_valid),
    .dior_n     (dior_n),
    .diow_n     (diow_n),
    .done       (done)
);

// File: tb/tb_ide_pio_strobe_gen.sv
`timescale 1ns/1ps
module tb_ide_pio_strobe_gen;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       cfg_we;
    logic [3:0] cfg_addr;
    logic [7:0] cfg_wdata;
    logic       req_valid, req_drive, req_write, req_narrow;
    logic       busy, addr_valid, dior_n, diow_n, done;

    int checks = 0;
    int fails  = 0;

    logic [3:0] m_set [2];
    logic [7:0] m_tim [2][3];

    always #5 clk = ~clk;

    ide_pio_strobe_gen dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .req_valid(req_valid), .req_drive(req_drive),
        .req_write(req_write), .req_narrow(req_narrow), .busy(busy),
        .addr_valid(addr_valid), .dior_n(dior_n), .diow_n(diow_n), .done(done)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // model follows R4/R5/R10 offset map
    task automatic wr_reg(input logic [3:0] a, input logic [7:0] d);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
        case (a)
            4'h0: m_set[0] = d[3:0];
            4'h1: m_set[1] = d[3:0];
            4'h4: m_tim[0][0] = d;
            4'h5: m_tim[0][1] = d;
            4'h6: m_tim[0][2] = d;
            4'h8: m_tim[1][0] = d;
            4'h9: m_tim[1][1] = d;
            4'hA: m_tim[1][2] = d;
            default: ;
        endcase
    endtask

    task automatic xfer(input bit drv, input bit wr, input bit nar, input bit hold, input string tag);
        int k, es, ea, er, ns, na, nr;
        bit ph_act, bad_strobe, bad_busy, bad_addr, seen_done;
        k  = nar ? 2 : (wr ? 1 : 0);
        es = int'(m_set[drv]) + 1;
        ea = int'(m_tim[drv][k][7:4]) + 1;
        er = int'(m_tim[drv][k][3:0]) + 1;
        ns = 0; na = 0; nr = 0;
        ph_act = 0; bad_strobe = 0; bad_busy = 0; bad_addr = 0; seen_done = 0;
        req_valid = 1'b1; req_drive = drv; req_write = wr; req_narrow = nar;
        @(negedge clk);
        if (!hold) req_valid = 1'b0;
        for (int i = 0; i < 64; i++) begin
            if (!busy) bad_busy = 1;
            if (done) begin
                seen_done = 1;
                break;
            end
            if (!addr_valid) bad_addr = 1;
            if (wr ? !dior_n : !diow_n) bad_strobe = 1;
            if (wr ? !diow_n : !dior_n) begin
                na++;
                ph_act = 1;
            end else if (!ph_act) begin
                ns++;
            end else begin
                nr++;
            end
            @(negedge clk);
        end
        req_valid = 1'b0;
        chk(ns == es, {tag, " R2 R4 setup length"}, ns, es);
        chk(na == ea, {tag, " R3 R6 active length"}, na, ea);
        chk(nr == er, {tag, " R3 R6 recovery length"}, nr, er);
        chk(!bad_strobe && !bad_addr && seen_done, {tag, " R7 strobe/addr/done"},
            int'(bad_strobe) + int'(bad_addr), int'(!seen_done));
        chk(!bad_busy, {tag, " R8 busy during transfer"}, int'(bad_busy), 0);
        @(negedge clk);
        chk(!busy && !done, {tag, hold ? " R9 idle after held request" : " R8 idle after done"},
            int'(busy), 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        rst_n = 1'b0; cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0;
        req_valid = 1'b0; req_drive = 1'b0; req_write = 1'b0; req_narrow = 1'b0;
        for (int d = 0; d < 2; d++) begin
            m_set[d] = '0;
            for (int k = 0; k < 3; k++) m_tim[d][k] = '0;
        end
        repeat (3) @(negedge clk);
        // R1: reset outputs
        chk(!busy, "R1 busy after reset", int'(busy), 0);
        chk(dior_n && diow_n, "R1 strobes high in reset", int'(dior_n) + int'(diow_n), 2);
        chk(!addr_valid && !done, "R1 addr/done low in reset", int'(addr_valid) + int'(done), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: cleared fields give one-clock phases
        for (int c = 0; c < 8; c++)
            xfer(c[0], c[1], c[2], 1'b0, "R1 post-reset");

        // R5/R6: distinct bytes for every drive and kind
        wr_reg(4'h0, 8'h02); wr_reg(4'h1, 8'h05);
        wr_reg(4'h4, 8'h13); wr_reg(4'h5, 8'h31); wr_reg(4'h6, 8'h24);
        wr_reg(4'h8, 8'h42); wr_reg(4'h9, 8'h05); wr_reg(4'hA, 8'h60);
        for (int c = 0; c < 8; c++)
            xfer(c[0], c[1], c[2], 1'b0, "R5 R6 select");

        // R2/R4: sweep master setup and read fields over 0..15, slave must not move
        for (int v = 0; v < 16; v++) begin
            wr_reg(4'h0, {4'hA, 4'(v)});
            wr_reg(4'h4, {4'(v), 4'(15 - v)});
            xfer(1'b0, 1'b0, 1'b0, 1'b0, "R2 sweep master");
            xfer(1'b1, 1'b1, 1'b0, 1'b0, "R4 slave untouched");
        end
        for (int v = 0; v < 16; v += 5) begin
            wr_reg(4'h1, {4'h3, 4'(v)});
            xfer(1'b0, 1'b1, 1'b1, 1'b0, "R4 master untouched");
            xfer(1'b1, 1'b0, 1'b1, 1'b0, "R4 slave set");
        end

        // R10: unused offsets change nothing
        wr_reg(4'h2, 8'hFF); wr_reg(4'h3, 8'hFF); wr_reg(4'h7, 8'hFF);
        wr_reg(4'hB, 8'hFF); wr_reg(4'hC, 8'hFF); wr_reg(4'hD, 8'hFF);
        wr_reg(4'hE, 8'hFF); wr_reg(4'hF, 8'hFF);
        for (int c = 0; c < 8; c++)
            xfer(c[0], c[1], c[2], 1'b0, "R10 ignored offsets");

        // R9: request held high through a transfer
        xfer(1'b1, 1'b0, 1'b0, 1'b1, "R9 held");
        xfer(1'b0, 1'b1, 1'b1, 1'b1, "R9 held");

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule